// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

This block turns one transfer descriptor into a stream of per-beat bus addresses for a copy engine. A descriptor names a region of rows: each side (source and destination) has its own first address and its own distance between the starts of consecutive rows. The row length in bytes and the number of rows are common to both sides. After a start handshake the generator presents one address pair per cycle. It advances to the next pair only when the bus side accepts the current beat. It flags the final beat of every row and the final beat of the whole region, and it pulses a completion strobe once the region has been walked.

Row length and row count are programmed as the value minus one. The data path width, `BEAT_BYTES` (a power of two, at least 2), fixes the address step within a row and the alignment of every programmed address and length. A side can be built as a streaming peripheral port: it then has no address, and its output is held at zero. A build without two-dimensional support ignores the row count and moves exactly one row. In cyclic mode the region is walked again from its first addresses, with no new start, for as long as the block is out of reset.

Top module: `strd2d_agen`

## Requirements
- R1: After reset, `start_ready` is 1 and `beat_valid`, `row_last`, `xfer_last` and `done` are 0.
- R2: A descriptor is taken only on a cycle where `start_valid` and `start_ready` are both 1. While a region is being walked, `start_ready` is 0, and `start_valid` together with new descriptor values leaves the addresses, flags and beat sequence unchanged.
- R3: On the cycle after a descriptor is taken, `beat_valid` is 1 and the outputs show the first beat: `src_addr` equals `src_base` and `dst_addr` equals `dst_base`.
- R4: Within a row, each beat accepted with `beat_accept` = 1 moves each memory-side address up by `BEAT_BYTES` on the next cycle. A cycle with `beat_accept` = 0 holds every output.
- R5: A row holds (`x_len_m1`+1)/`BEAT_BYTES` beats and the region holds `y_len_m1`+1 rows, so the bytes moved equal row length times row count. `row_last` is 1 exactly on the last beat of each row. `xfer_last` is 1 exactly on the last beat of the last row.
- R6: The first beat of each row after the first is at the previous row's first address plus that side's stride, for source and destination independently. A stride may be larger than the row length.
- R7: When the last beat is accepted in non-cyclic mode, `done` is 1 for exactly the next cycle, and in that cycle `beat_valid` is 0 and `start_ready` is 1.
- R8: With `cyclic` = 1 at start, accepting the last beat is followed by the first beat of the same region (both base addresses again), `beat_valid` stays 1, and `done` stays 0.
- R9: When built with `TWO_D` = 0, `y_len_m1` is ignored: the region is one row of `x_len_m1`+1 bytes, and its last beat carries both `row_last` and `xfer_last`.
- R10: A side built as a streaming port (`SRC_IS_MEM` or `DST_IS_MEM` = 0) has its address output at 0 on every cycle.
- R11: Input contract: when a descriptor is taken, both base addresses have their low log2(`BEAT_BYTES`) bits at 0, and the low log2(`BEAT_BYTES`) bits of `x_len_m1` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Descriptor offered |
| start_ready | output | 1 | Generator idle, descriptor can be taken |
| cyclic | input | 1 | Repeat the region without a new start |
| src_base | input | ADDR_W | First source address |
| src_stride | input | ADDR_W | Source distance between row starts |
| dst_base | input | ADDR_W | First destination address |
| dst_stride | input | ADDR_W | Destination distance between row starts |
| x_len_m1 | input | XLEN_W | Row length in bytes minus one |
| y_len_m1 | input | ROWS_W | Row count minus one |
| beat_accept | input | 1 | Bus side takes the current beat |
| beat_valid | output | 1 | Current address pair is valid |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| row_last | output | 1 | Current beat ends a row |
| xfer_last | output | 1 | Current beat ends the region |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The assertions rely on the R11 contract: base addresses aligned to the beat size, and row lengths that are whole multiples of it. Without that contract the per-beat step and the row counts lose their meaning. The bench builds every descriptor from a beat count, so `x_len_m1` is always a beat multiple minus one, and all bases are multiples of 4. Row lengths, row counts, strides smaller and larger than the row, address wrap at the top of the space, and accept stalls are swept together. The descriptor lines are overwritten with misaligned values only while a region is being walked, when the generator must not take them.

// File: rtl/strd2d_pkg.sv
package strd2d_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } strd2d_state_e;

    // position of the current beat inside the region
    typedef struct packed {
        logic row_end;
        logic xfer_end;
    } strd2d_pos_t;

    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/strd2d_walk_ctr.sv
module strd2d_walk_ctr
    import strd2d_pkg::*;
#(
    parameter int COL_W = 6,
    parameter int ROW_W = 4,
    parameter bit TWO_D = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [COL_W-1:0] cols_m1,
    input  logic [ROW_W-1:0] rows_m1,
    output strd2d_pos_t      pos
);

    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [ROW_W-1:0] row_lim;

    generate
        if (TWO_D) begin : g_rows
            assign row_lim = rows_m1;
        end else begin : g_one_row
            logic unused_rows;
            assign unused_rows = ^rows_m1;
            assign row_lim     = '0;
        end
    endgenerate

    assign pos.row_end  = (col == cols_m1);
    assign pos.xfer_end = pos.row_end && (row == row_lim);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (pos.row_end) begin
                col <= '0;
                row <= pos.xfer_end ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // R5
    col_in_row_chk: assert property (@(posedge clk) disable iff (rst)
        !load |-> col <= cols_m1);

    // R5
    row_in_region_chk: assert property (@(posedge clk) disable iff (rst)
        !load |-> row <= row_lim);

    // R5
    row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        step && pos.row_end && !load |=> col == '0);

endmodule

// File: rtl/strd2d_side.sv
module strd2d_side
    import strd2d_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BEAT_BYTES = 4,
    parameter bit IS_MEM     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  strd2d_pos_t       pos,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] BEAT_INC = ADDR_W'(BEAT_BYTES);

    generate
        if (IS_MEM) begin : g_mem
            logic [ADDR_W-1:0] row_base;
            logic [ADDR_W-1:0] cur;
            logic [ADDR_W-1:0] next_row;

            assign next_row = row_base + stride;
            assign addr     = cur;

            always_ff @(posedge clk) begin
                if (rst) begin
                    row_base <= '0;
                    cur      <= '0;
                end else if (load || (step && pos.xfer_end)) begin
                    row_base <= base;
                    cur      <= base;
                end else if (step && pos.row_end) begin
                    row_base <= next_row;
                    cur      <= next_row;
                end else if (step) begin
                    cur <= cur + BEAT_INC;
                end
            end

            // R4
            beat_step_chk: assert property (@(posedge clk) disable iff (rst)
                step && !pos.row_end && !load |=> addr == $past(addr) + BEAT_INC);

            // R4
            stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !step && !load |=> $stable(addr));

            // R6
            row_step_chk: assert property (@(posedge clk) disable iff (rst)
                step && pos.row_end && !pos.xfer_end && !load
                |=> addr == $past(row_base) + $past(stride));
        end else begin : g_stream
            logic unused_side;
            assign unused_side = ^{load, step, pos, base, stride};
            assign addr        = '0;
        end
    endgenerate

endmodule

// File: rtl/strd2d_agen.sv
module strd2d_agen
    import strd2d_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int XLEN_W     = 8,
    parameter int ROWS_W     = 4,
    parameter int BEAT_BYTES = 4,
    parameter bit TWO_D      = 1'b1,
    parameter bit SRC_IS_MEM = 1'b1,
    parameter bit DST_IS_MEM = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic              cyclic,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] src_stride,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ADDR_W-1:0] dst_stride,
    input  logic [XLEN_W-1:0] x_len_m1,
    input  logic [ROWS_W-1:0] y_len_m1,
    input  logic              beat_accept,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              row_last,
    output logic              xfer_last,
    output logic              done
);

    localparam int BEAT_LG = $clog2(BEAT_BYTES);
    localparam int COL_W   = XLEN_W - BEAT_LG;

    strd2d_state_e     state;
    logic              cyc_q;
    logic [COL_W-1:0]  cols_q;
    logic [ROWS_W-1:0] rows_q;
    logic [ADDR_W-1:0] src_base_q, src_stride_q;
    logic [ADDR_W-1:0] dst_base_q, dst_stride_q;
    logic [ADDR_W-1:0] src_base_sel, dst_base_sel;
    logic              load, step;
    strd2d_pos_t       pos;

    assign start_ready  = (state == ST_IDLE);
    assign beat_valid   = (state == ST_RUN);
    assign load         = start_valid && start_ready;
    assign step         = beat_valid && beat_accept;
    assign src_base_sel = load ? src_base : src_base_q;
    assign dst_base_sel = load ? dst_base : dst_base_q;
    assign row_last     = beat_valid && pos.row_end;
    assign xfer_last    = beat_valid && pos.xfer_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cyc_q        <= 1'b0;
            cols_q       <= '0;
            rows_q       <= '0;
            src_base_q   <= '0;
            src_stride_q <= '0;
            dst_base_q   <= '0;
            dst_stride_q <= '0;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state        <= ST_RUN;
                cyc_q        <= cyclic;
                cols_q       <= x_len_m1[XLEN_W-1:BEAT_LG];
                rows_q       <= y_len_m1;
                src_base_q   <= src_base;
                src_stride_q <= src_stride;
                dst_base_q   <= dst_base;
                dst_stride_q <= dst_stride;
            end else if (step && pos.xfer_end && !cyc_q) begin
                state <= ST_IDLE;
                done  <= 1'b1;
            end
        end
    end

    strd2d_walk_ctr #(
        .COL_W (COL_W),
        .ROW_W (ROWS_W),
        .TWO_D (TWO_D)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step),
        .cols_m1 (cols_q),
        .rows_m1 (rows_q),
        .pos     (pos)
    );

    strd2d_side #(
        .ADDR_W     (ADDR_W),
        .BEAT_BYTES (BEAT_BYTES),
        .IS_MEM     (SRC_IS_MEM)
    ) u_src (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .pos    (pos),
        .base   (src_base_sel),
        .stride (src_stride_q),
        .addr   (src_addr)
    );

    strd2d_side #(
        .ADDR_W     (ADDR_W),
        .BEAT_BYTES (BEAT_BYTES),
        .IS_MEM     (DST_IS_MEM)
    ) u_dst (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .pos    (pos),
        .base   (dst_base_sel),
        .stride (dst_stride_q),
        .addr   (dst_addr)
    );

    initial begin
        // R11
        beat_pow2_chk: assert (is_pow2(BEAT_BYTES) && BEAT_BYTES >= 2);
    end

    // R11
    desc_align_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (src_base[BEAT_LG-1:0] == '0) && (dst_base[BEAT_LG-1:0] == '0)
                 && (&x_len_m1[BEAT_LG-1:0]));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(xfer_last && beat_accept && !cyc_q));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    cyclic_stay_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && cyc_q |=> beat_valid && !done);

    // R5
    last_in_row_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_last |-> row_last);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !beat_accept |=> beat_valid && $stable(src_addr) && $stable(dst_addr));

endmodule

// File: tb/sim_strd2d_agen.sv
module sim_strd2d_agen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // instance u0: both sides memory, two-dimensional
    logic        sv0 = 0, cyc0 = 0, acc0 = 0;
    logic [15:0] sb0 = 0, ss0 = 0, db0 = 0, ds0 = 0;
    logic [7:0]  xl0 = 0;
    logic [3:0]  yl0 = 0;
    logic        rdy0, bv0, rl0, xl0_o, dn0;
    logic [15:0] sa0, da0;

    strd2d_agen #(.ADDR_W(16), .XLEN_W(8), .ROWS_W(4), .BEAT_BYTES(4),
                  .TWO_D(1), .SRC_IS_MEM(1), .DST_IS_MEM(1)) u0 (
        .clk(clk), .rst(rst), .start_valid(sv0), .start_ready(rdy0), .cyclic(cyc0),
        .src_base(sb0), .src_stride(ss0), .dst_base(db0), .dst_stride(ds0),
        .x_len_m1(xl0), .y_len_m1(yl0), .beat_accept(acc0), .beat_valid(bv0),
        .src_addr(sa0), .dst_addr(da0), .row_last(rl0), .xfer_last(xl0_o), .done(dn0));

    // instance u1: one-dimensional, destination is a streaming port
    logic        sv1 = 0, acc1 = 0;
    logic [15:0] sb1 = 0;
    logic [7:0]  xl1 = 0;
    logic [3:0]  yl1 = 0;
    logic        rdy1, bv1, rl1, xf1, dn1;
    logic [15:0] sa1, da1;

    strd2d_agen #(.ADDR_W(16), .XLEN_W(8), .ROWS_W(4), .BEAT_BYTES(4),
                  .TWO_D(0), .SRC_IS_MEM(1), .DST_IS_MEM(0)) u1 (
        .clk(clk), .rst(rst), .start_valid(sv1), .start_ready(rdy1), .cyclic(1'b0),
        .src_base(sb1), .src_stride(16'h0040), .dst_base(16'h0000), .dst_stride(16'h0000),
        .x_len_m1(xl1), .y_len_m1(yl1), .beat_accept(acc1), .beat_valid(bv1),
        .src_addr(sa1), .dst_addr(da1), .row_last(rl1), .xfer_last(xf1), .done(dn1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin : watchdog
        int cnt;
        cnt++;
        if (cnt > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cnt);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // walk one region on u0 and compare every beat against an arithmetic model
    task automatic run0(input int xb, input int ny, input logic [15:0] s_b, input logic [15:0] s_s,
                        input logic [15:0] d_b, input logic [15:0] d_s, input bit cyc, input int passes);
        int beat;
        beat = 0;
        @(negedge clk);
        sb0 = s_b; ss0 = s_s; db0 = d_b; ds0 = d_s;
        xl0 = 8'(xb * 4 - 1); yl0 = 4'(ny - 1); cyc0 = cyc; sv0 = 1'b1;
        @(negedge clk);
        sv0 = 1'b0;
        for (int p = 0; p < passes; p++) begin
            for (int r = 0; r < ny; r++) begin
                for (int c = 0; c < xb; c++) begin
                    logic [15:0] es, ed;
                    es = 16'(s_b + r * s_s + c * 4);
                    ed = 16'(d_b + r * d_s + c * 4);
                    if (beat % 3 == 1) begin
                        acc0 = 1'b0;
                        @(negedge clk);
                        check("R4 stall src", sa0, es);
                        check("R4 stall dst", da0, ed);
                    end
                    check(beat == 0 ? "R3 valid" : "R8 valid", bv0, 1);
                    check(c == 0 ? "R6 src row start" : "R4 src step", sa0, es);
                    check(c == 0 ? "R6 dst row start" : "R4 dst step", da0, ed);
                    check("R5 row_last", rl0, (c == xb - 1));
                    check("R5 xfer_last", xl0_o, (c == xb - 1) && (r == ny - 1));
                    check("R2 start_ready busy", rdy0, 0);
                    check("R8 no done", dn0, 0);
                    if (beat == 0) begin
                        // R2: new descriptor offered while busy must be ignored
                        sv0 = 1'b1; sb0 = 16'h1232; db0 = 16'h0bad; ss0 = 16'h0003; xl0 = 8'h02;
                    end
                    acc0 = 1'b1;
                    @(negedge clk);
                    acc0 = 1'b0; sv0 = 1'b0;
                    beat++;
                end
            end
        end
        if (!cyc) begin
            check("R7 done", dn0, 1);
            check("R7 valid low", bv0, 0);
            check("R7 ready", rdy0, 1);
            @(negedge clk);
            check("R7 done one cycle", dn0, 0);
        end else begin
            check("R8 wrap src", sa0, s_b);
            check("R8 wrap dst", da0, d_b);
            check("R8 still valid", bv0, 1);
            check("R8 done low", dn0, 0);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            check("R1 ready after reset", rdy0, 1);
        end
    endtask

    task automatic run1(input int xb, input int ny, input logic [15:0] s_b);
        @(negedge clk);
        sb1 = s_b; xl1 = 8'(xb * 4 - 1); yl1 = 4'(ny - 1); sv1 = 1'b1;
        @(negedge clk);
        sv1 = 1'b0;
        for (int c = 0; c < xb; c++) begin
            check("R9 valid", bv1, 1);
            check("R9 src", sa1, 16'(s_b + c * 4));
            check("R10 stream dst zero", da1, 0);
            check("R9 row_last", rl1, (c == xb - 1));
            check("R9 xfer_last", xf1, (c == xb - 1));
            acc1 = 1'b1;
            @(negedge clk);
            acc1 = 1'b0;
        end
        check("R9 done after one row", dn1, 1);
        check("R9 idle", bv1, 0);
        check("R10 dst zero idle", da1, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check("R1 ready", rdy0, 1);
        check("R1 valid", bv0, 0);
        check("R1 row_last", rl0, 0);
        check("R1 xfer_last", xl0_o, 0);
        check("R1 done", dn0, 0);
        check("R1 u1 ready", rdy1, 1);
        check("R1 u1 done", dn1, 0);

        // R5 R6 sweep: row beats, rows, strides below and above row length
        for (int xb = 1; xb <= 4; xb++) begin
            for (int ny = 1; ny <= 3; ny++) begin
                for (int s = 0; s < 3; s++) begin
                    run0(xb, ny,
                         16'(16'h0100 * (xb + ny) + 16 * s),
                         16'(xb * 4 + 12 * s - 4 * (s == 0)),
                         16'(16'h2000 + 16'h0040 * s),
                         16'(64 - 8 * s),
                         1'b0, 1);
                end
            end
        end
        // address wrap at the top of the space
        run0(3, 3, 16'hFFE0, 16'h0010, 16'hFFF8, 16'h0024, 1'b0, 1);
        // R8 cyclic, two passes
        run0(2, 3, 16'h0400, 16'h0020, 16'h0800, 16'h0010, 1'b1, 2);
        run0(1, 1, 16'h0040, 16'h0004, 16'h0080, 16'h0004, 1'b1, 3);

        // R9 R10 one-dimensional build with a streaming destination
        for (int xb = 1; xb <= 5; xb++) begin
            run1(xb, 4, 16'(16'h0300 + xb * 32));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule